// File: doc/BRIEF.md
# Continuous-Phase MSK Transmit Tone Generator

This block turns a serial stream of data bits into a sampled two-tone signal for a radio transmit path. It runs from a 3.6864 MHz master clock and hands the host a bit clock at 2400 Hz or 1200 Hz. The host places each bit on the data input and the block takes it on the rising edge of that bit clock. For every bit the block emits a signed 8-bit sine code at a fixed sample rate. A 1 bit gives 1200 Hz at either rate. A 0 bit gives 2400 Hz at the fast rate and 1800 Hz at the slow rate. The phase carries over across bit boundaries, so the waveform never jumps.

Two path-select inputs control the block. While `sel_hold` is low the bit clock runs. While it is high the bit clock sits high. Bits are only taken while `sel_data` is high. When the host raises `sel_hold` after the last bit, the bit already in flight plays out to its full length. The output then drops to zero. This is bounded by one slow bit period (about 833 us), well inside a 2 ms window. Conversion to analogue, filtering and spectral shaping happen downstream.

The default parameters give 48 master clocks per sample (76.8 kHz) and 32 samples per fast bit (1536 clocks per bit). The phase accumulator is 16 bits wide.

Top module: `msk_tone_tx`

## Requirements
- R1: During and straight after reset, with `sel_hold` high, `bit_clk` is 1 and `tone_sample` is 0.
- R2: In every cycle that follows a cycle in which `sel_hold` was high, `bit_clk` is 1.
- R3: Let H be BIT_DIV/2 clocks for `rate_slow`=0, or BIT_DIV clocks for `rate_slow`=1, where BIT_DIV = CLK_PER_SAMPLE*SAMPLES_PER_BIT. The first clock edge that samples `sel_hold` low (with the block stopped) starts the bit clock. `bit_clk` then goes low, and it is first seen high H+1 clock edges after the start. After that it has period 2H with exactly H cycles high.
- R4: A bit is taken from `tx_bit` at the clock edge that ends the first cycle in which `bit_clk` is high, if `sel_data` is 1 then. That edge is the bit boundary, and the bit lasts 2H clocks.
- R5: The phase step per sample is U = 2^PHASE_W/(2*SAMPLES_PER_BIT) for a 1 bit. For a 0 bit it is 2U at the fast rate and 3U/2 at the slow rate. So a 1 bit gives 1200 Hz, and a 0 bit gives 2400 Hz (fast) or 1800 Hz (slow).
- R6: Within a bit, `tone_sample` changes only at the boundary edge and then every CLK_PER_SAMPLE edges. Each new value is round-half-away(127*sin(2*pi*(p+0.5)/256)), where p is the top 8 bits of the phase. After the sample is taken, the phase advances by the step.
- R7: The phase is not reset at a boundary between two bits. The step changes only at boundaries, so the waveform is continuous.
- R8: After `sel_hold` rises, no further bit is taken. The bit in flight completes its full 2H clocks. At its end boundary `tone_sample` becomes 0 and the phase returns to 0. This tail never exceeds 2*BIT_DIV clocks.
- R9: Whenever no bit is in flight, including the half period before the first boundary, `tone_sample` is 0.
- R10: If `sel_data` is 0 at a boundary, no bit is taken. `tone_sample` becomes 0 at that edge while `bit_clk` keeps running.
- R11: The rate is latched when the bit clock starts. A change of `rate_slow` while it runs has no effect on the period or the tones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (3.6864 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| rate_slow | input | 1 | 0 selects 2400 bit/s, 1 selects 1200 bit/s; latched at start |
| sel_hold | input | 1 | 1 stops the bit clock (held high) and ends the message |
| sel_data | input | 1 | 1 lets bits be taken at bit-clock rising edges |
| tx_bit | input | 1 | Data bit offered to the block |
| bit_clk | output | 1 | Bit clock to the host |
| tone_sample | output | 8 | Signed sine sample, zero when idle |

## Verification
The bench drives every 4-bit pattern at both rates. It compares each output cycle with an arithmetic model of the phase and the sine. A design that resets the phase at boundaries, or switches the step mid-bit, gives a sample jump that the model flags on the next strobe. The first bit-clock edge and the period are timed in clocks, so a divider that is off by one, or that uses a full period before the first edge, shows up as a count error. The bench also covers three cases: a rate change while running, which must be ignored; a boundary with `sel_data` low, which must go silent; and the end tail, where a design that cuts the last bit short or never returns to zero fails.

// File: rtl/mskt_pkg.sv
`timescale 1ns/1ps
package mskt_pkg;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef logic signed [7:0] sample_t;

    typedef struct packed {
        logic start;     // bit clock begins this cycle
        logic boundary;  // bit boundary this cycle
        logic capture;   // a new bit is taken at this boundary
    } clk_evt_t;

    localparam int SINE_AMP = 127;
    localparam int QTR_LEN  = 64;

    // magnitude of one quarter-wave entry, centred in its slot
    function automatic logic [6:0] qtr_mag(input int idx);
        real ang;
        ang = 6.283185307179586 * (real'(idx) + 0.5) / 256.0;
        return 7'($rtoi(real'(SINE_AMP) * $sin(ang) + 0.5));
    endfunction

    // phase step for a bit value at a rate, unit is the 1200 Hz step
    function automatic int unsigned tone_step(input rate_e rate,
                                              input logic bit_v,
                                              input int unsigned unit);
        if (bit_v)
            return unit;
        else if (rate == RATE_FAST)
            return 2 * unit;
        else
            return (3 * unit) / 2;
    endfunction

endpackage

// File: rtl/mskt_bitclk.sv
`timescale 1ns/1ps
module mskt_bitclk
    import mskt_pkg::*;
#(
    parameter int BIT_DIV = 1536,
    parameter int CNT_W   = $clog2(2 * BIT_DIV)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rate_slow,
    input  logic     sel_hold,
    input  logic     sel_data,
    input  logic     busy,
    output logic     running,
    output rate_e    rate_q,
    output clk_evt_t evt,
    output logic     bit_clk
);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(BIT_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(2 * BIT_DIV - 1);
    localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(BIT_DIV / 2);
    localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(BIT_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_v;
    logic [CNT_W-1:0] half_v;

    always_comb begin
        last_v = (rate_q == RATE_SLOW) ? SLOW_LAST : FAST_LAST;
        half_v = (rate_q == RATE_SLOW) ? SLOW_HALF : FAST_HALF;
    end

    assign evt.start    = !sel_hold && !running;
    assign evt.boundary = (running || busy) && (cnt_q == half_v);
    assign evt.capture  = evt.boundary && running && sel_data;
    assign bit_clk      = !running || (cnt_q >= half_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt_q   <= '0;
            rate_q  <= RATE_FAST;
        end else begin
            running <= !sel_hold;
            if (evt.start) begin
                cnt_q  <= '0;
                rate_q <= rate_e'(rate_slow);
            end else if (running || busy) begin
                cnt_q <= (cnt_q == last_v) ? '0 : cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R2: holding the path parks the bit clock high on the next cycle
    p_hold_parks_clk_r2: assert property (@(posedge clk) disable iff (rst)
        sel_hold |=> bit_clk);

    // R3: the first half period after a start is low
    p_first_half_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> !bit_clk);

    // R4: bits are only taken while the bit clock is high
    p_take_on_high_r4: assert property (@(posedge clk) disable iff (rst)
        evt.capture |-> bit_clk);

    // R11: the latched rate stays fixed while the bit clock runs
    p_rate_locked_r11: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(rate_q));

endmodule

// File: rtl/mskt_sine.sv
`timescale 1ns/1ps
module mskt_sine
    import mskt_pkg::*;
(
    input  logic [7:0] idx,
    output sample_t    val
);
    logic [6:0] qtr [QTR_LEN];

    for (genvar g = 0; g < QTR_LEN; g++) begin : g_qtr
        assign qtr[g] = qtr_mag(g);
    end

    logic [1:0] quad;
    logic [5:0] addr;
    logic [6:0] mag;

    always_comb begin
        quad = idx[7:6];
        addr = quad[0] ? ~idx[5:0] : idx[5:0];
        mag  = qtr[addr];
        val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    // R6: codes stay inside the symmetric +/-127 range
    always_comb begin
        p_code_range_r6: assert (val != -8'sd128);
    end

endmodule

// File: rtl/mskt_phase.sv
`timescale 1ns/1ps
module mskt_phase
    import mskt_pkg::*;
#(
    parameter int          PHASE_W        = 16,
    parameter int          CLK_PER_SAMPLE = 48,
    parameter int unsigned UNIT           = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  clk_evt_t   evt,
    input  rate_e      rate_q,
    input  logic       tx_bit,
    input  sample_t    sine_val,
    output logic [7:0] sine_idx,
    output logic       busy,
    output sample_t    sample_q
);
    localparam int SC_W = (CLK_PER_SAMPLE > 1) ? $clog2(CLK_PER_SAMPLE) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(CLK_PER_SAMPLE - 1);
    localparam logic [SC_W-1:0] SC_ONE  = SC_W'(1);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] inc_q;
    logic [PHASE_W-1:0] inc_new;
    logic [SC_W-1:0]    sc_q;

    assign inc_new  = PHASE_W'(tone_step(rate_q, tx_bit, UNIT));
    assign sine_idx = phase_q[PHASE_W-1 -: 8];

    always_ff @(posedge clk) begin
        if (rst || evt.start) begin
            busy     <= 1'b0;
            phase_q  <= '0;
            inc_q    <= '0;
            sc_q     <= '0;
            sample_q <= '0;
        end else if (evt.boundary) begin
            if (evt.capture) begin
                busy     <= 1'b1;
                inc_q    <= inc_new;
                sample_q <= sine_val;
                phase_q  <= phase_q + inc_new;
                sc_q     <= SC_ONE;
            end else begin
                busy     <= 1'b0;
                phase_q  <= '0;
                inc_q    <= '0;
                sc_q     <= '0;
                sample_q <= '0;
            end
        end else if (busy) begin
            sc_q <= (sc_q == SC_LAST) ? '0 : sc_q + 1'b1;
            if (sc_q == '0) begin
                sample_q <= sine_val;
                phase_q  <= phase_q + inc_q;
            end
        end
    end

    // R7: the step is fixed between boundaries
    p_step_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        busy && !evt.boundary && !evt.start |=> $stable(inc_q));

    // R6: between strobes the sample and phase hold
    p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
        busy && !evt.boundary && !evt.start && (sc_q != '0)
        |=> $stable(sample_q) && $stable(phase_q));

    // R9: no bit in flight means a zero output
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sample_q == '0));

endmodule

// File: rtl/msk_tone_tx.sv
`timescale 1ns/1ps
module msk_tone_tx
    import mskt_pkg::*;
#(
    parameter int CLK_PER_SAMPLE  = 48,
    parameter int SAMPLES_PER_BIT = 32,
    parameter int PHASE_W         = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rate_slow,
    input  logic       sel_hold,
    input  logic       sel_data,
    input  logic       tx_bit,
    output logic       bit_clk,
    output logic [7:0] tone_sample
);
    localparam int          BIT_DIV = CLK_PER_SAMPLE * SAMPLES_PER_BIT;
    localparam int          CNT_W   = $clog2(2 * BIT_DIV);
    localparam int unsigned UNIT    = (1 << PHASE_W) / (2 * SAMPLES_PER_BIT);
    localparam logic [CNT_W:0] FLUSH_MAX = (CNT_W + 1)'(2 * BIT_DIV);

    logic       running;
    logic       busy;
    rate_e      rate_q;
    clk_evt_t   evt;
    logic [7:0] sine_idx;
    sample_t    sine_val;
    sample_t    sample_q;

    mskt_bitclk #(
        .BIT_DIV (BIT_DIV),
        .CNT_W   (CNT_W)
    ) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .rate_slow (rate_slow),
        .sel_hold  (sel_hold),
        .sel_data  (sel_data),
        .busy      (busy),
        .running   (running),
        .rate_q    (rate_q),
        .evt       (evt),
        .bit_clk   (bit_clk)
    );

    mskt_phase #(
        .PHASE_W        (PHASE_W),
        .CLK_PER_SAMPLE (CLK_PER_SAMPLE),
        .UNIT           (UNIT)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rate_q   (rate_q),
        .tx_bit   (tx_bit),
        .sine_val (sine_val),
        .sine_idx (sine_idx),
        .busy     (busy),
        .sample_q (sample_q)
    );

    mskt_sine u_sine (
        .idx (sine_idx),
        .val (sine_val)
    );

    assign tone_sample = sample_q;

    // length of the current tail after the bit clock stopped
    logic [CNT_W:0] flush_cyc;
    always_ff @(posedge clk) begin
        if (rst)
            flush_cyc <= '0;
        else if (!running && busy)
            flush_cyc <= flush_cyc + 1'b1;
        else
            flush_cyc <= '0;
    end

    // R8: the tail after stopping stays within one slow bit
    p_tail_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        flush_cyc <= FLUSH_MAX);

    // R9: stopped and drained means silence at the port
    p_quiet_port_r9: assert property (@(posedge clk) disable iff (rst)
        !running && !busy |-> (tone_sample == 8'd0));

endmodule

// File: tb/msk_tone_tx_bench.sv
`timescale 1ns/1ps
module msk_tone_tx_bench;

    localparam int CPS   = 4;
    localparam int SPB   = 8;
    localparam int PW    = 16;
    localparam int BD    = CPS * SPB;
    localparam int UNIT  = (1 << PW) / (2 * SPB);
    localparam int PMASK = (1 << PW) - 1;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_slow = 1'b0;
    logic sel_hold = 1'b1;
    logic sel_data = 1'b1;
    logic tx_bit = 1'b0;
    logic bit_clk;
    logic signed [7:0] tone_sample;

    always #2.5 clk = ~clk;

    msk_tone_tx #(
        .CLK_PER_SAMPLE  (CPS),
        .SAMPLES_PER_BIT (SPB),
        .PHASE_W         (PW)
    ) u_msk_tone_tx (
        .clk         (clk),
        .rst         (rst),
        .rate_slow   (rate_slow),
        .sel_hold    (sel_hold),
        .sel_data    (sel_data),
        .tx_bit      (tx_bit),
        .bit_clk     (bit_clk),
        .tone_sample (tone_sample)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ideal_sine(input int p);
        real v;
        v = 127.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else return -$rtoi(-v + 0.5);
    endfunction

    // arithmetic model of the output, stepped at each falling clock edge
    bit    model_on = 1'b0;
    int    m_exp = 0, m_phi = 0, m_k = 0, m_inc = 0, m_len = BD;
    bit    m_busy = 1'b0, m_run = 1'b0, m_prev = 1'b1, m_slow = 1'b0;
    string m_tag = "R1";

    always @(negedge clk) begin
        bit rise;
        cyc++;
        if (rst) begin
            m_exp = 0; m_phi = 0; m_k = 0; m_busy = 1'b0; m_run = 1'b0;
            m_prev = bit_clk; m_tag = "R1";
        end else begin
            if (model_on)
                chk(int'(tone_sample) == m_exp, m_tag, int'(tone_sample), m_exp);
            rise = bit_clk && !m_prev && m_run;
            if (!sel_hold && !m_run) begin
                m_busy = 1'b0; m_phi = 0; m_exp = 0;
                m_slow = rate_slow; m_len = rate_slow ? 2 * BD : BD;
                m_tag = "R9 start";
            end else if (rise) begin
                if (sel_data) begin
                    m_busy = 1'b1;
                    m_inc = tx_bit ? UNIT : (m_slow ? (3 * UNIT) / 2 : 2 * UNIT);
                    m_exp = ideal_sine((m_phi >> (PW - 8)) & 255);
                    m_phi = (m_phi + m_inc) & PMASK;
                    m_k = 1;
                    m_tag = "R7 boundary";
                end else begin
                    m_busy = 1'b0; m_phi = 0; m_exp = 0;
                    m_tag = "R10 no take";
                end
            end else if (m_busy) begin
                if (m_k == m_len) begin
                    m_busy = 1'b0; m_phi = 0; m_exp = 0;
                    m_tag = "R8 tail end";
                end else begin
                    if (m_k % CPS == 0) begin
                        m_exp = ideal_sine((m_phi >> (PW - 8)) & 255);
                        m_phi = (m_phi + m_inc) & PMASK;
                        m_tag = "R4 R5 strobe";
                    end else begin
                        m_tag = "R6 hold";
                    end
                    m_k++;
                end
            end else begin
                m_tag = "R9 idle";
            end
            m_run = !sel_hold;
            m_prev = bit_clk;
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (!done && cyc > LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input bit slow, input int nbits, input logic [15:0] pat,
                        input bit flip_rate, input int drop_at);
        int n;
        int last_rise;
        int rises;
        int half;
        string preq;
        half = slow ? BD : BD / 2;
        preq = flip_rate ? "R11 period" : "R3 period";
        @(posedge clk); #1;
        rate_slow = slow; tx_bit = pat[0]; sel_data = 1'b1; sel_hold = 1'b0;
        @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_clk && n < 1000);
        chk(n == half + 1, "R3 first edge", n, half + 1);
        last_rise = cyc;
        rises = 1;
        while (rises < nbits) begin
            do @(negedge clk); while (bit_clk);
            chk(cyc - last_rise == half, "R3 high time", cyc - last_rise, half);
            @(posedge clk); #1;
            tx_bit = pat[rises];
            if (flip_rate) rate_slow = ~rate_slow;
            if (rises == drop_at) sel_data = 1'b0;
            do @(negedge clk); while (!bit_clk);
            chk(cyc - last_rise == 2 * half, preq, cyc - last_rise, 2 * half);
            last_rise = cyc;
            rises++;
        end
        do @(negedge clk); while (bit_clk);
        @(posedge clk); #1;
        sel_hold = 1'b1; sel_data = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4 * BD + 8; i++) begin
            @(negedge clk);
            chk(bit_clk == 1'b1, "R2 parked high", int'(bit_clk), 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(bit_clk == 1'b1, "R1 reset clk", int'(bit_clk), 1);
        chk(tone_sample == 8'sd0, "R1 reset sample", int'(tone_sample), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(bit_clk == 1'b1, "R1 after reset clk", int'(bit_clk), 1);
        chk(tone_sample == 8'sd0, "R1 after reset sample", int'(tone_sample), 0);
        model_on = 1'b1;

        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 16; p++) begin
                send(s[0], 6, 16'(p * 4 + 2), 1'b0, -1);
            end
        end
        send(1'b0, 8, 16'h00A5, 1'b1, -1);
        send(1'b1, 8, 16'h003C, 1'b1, -1);
        send(1'b0, 6, 16'h002D, 1'b0, 3);
        send(1'b1, 6, 16'h0033, 1'b0, 2);
        send(1'b1, 14, 16'h0F0F, 1'b0, -1);
        send(1'b0, 14, 16'h0000, 1'b0, -1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule